// File: doc/BRIEF.md
# Interleaved Sorter Input Dispatcher

This block sits in front of a bank of parallel insertion sorters. Each cycle it takes a set of up to W entries, each made of a valid bit, a tag and a data word, where W is a power of two. It routes every entry to the sorter whose index equals the tag taken modulo W, which is the low log2(W) bits of the tag. Downstream, each sorter sees one insert port with a one-cycle valid strobe.

When two or more entries in one set target the same sorter, only the entry on the lowest-numbered input slot is forwarded at once. The rest are parked in a holding buffer, one entry per input slot above slot 0, together with their tags and data. While anything is parked, a stall output is high and any new input set is discarded. The parked entries drain under the same lowest-slot-wins rule, with at most one insert per sorter per cycle. If every entry in a set hits one sorter, the set takes W cycles, the same as a single sorter.

Top module: `sorter_dispatch`

## Requirements
- R1: An accepted entry with tag T appears on insert port T mod W (the low log2(W) tag bits), carrying its own tag and data, with its valid strobe high for exactly the one cycle after the clock edge that accepted it.
- R2: When several valid entries in one set share a target port, the entry on the lowest-numbered input slot is forwarded in the first cycle.
- R3: Entries that lose arbitration are kept with their tag and data and are forwarded unchanged in later cycles.
- R4: The stall output is high exactly while the holding buffer is non-empty. It rises in the cycle after a colliding set is accepted and stays low after a set with no collisions.
- R5: While stall is high, input sets are ignored and none of their entries ever reach an insert port.
- R6: While draining, each port receives at most one insert per cycle, and parked entries that share a port go out in ascending input-slot order. K entries on one port need K cycles in all.
- R7: A set whose valid entries all target different ports is forwarded completely in one cycle.
- R8: Input slots whose valid bit is low are ignored and never cause a collision.
- R9: After reset, all insert strobes are low and stall is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | WAYS | Per-slot entry valid |
| inTag | input | WAYS*TAG_W | Per-slot sort tag |
| inData | input | WAYS*DATA_W | Per-slot payload |
| outValid | output | WAYS | Per-sorter insert strobe |
| outTag | output | WAYS*TAG_W | Per-sorter insert tag |
| outData | output | WAYS*DATA_W | Per-sorter insert payload |
| stall | output | 1 | High while parked entries remain; input ignored |

## Verification
The bound assertions check on every cycle that slot 0 always reaches its own port, that a set with at most one entry never raises stall, that every stalled cycle delivers at least one insert and never more than W-1, and that accepted sets produce no more inserts than they had valid entries. The directed scenarios are needed for the things those local properties cannot show: the exact drain order across several cycles, the tags and data carried through the buffer, the length of the stall window, and the fact that a set offered during stall never shows up on any port.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  // Strobes from the arbitration control into the datapath
  typedef struct packed {
    logic loadFromInput; // arbitrate the live input set; losers are captured
    logic drainBuffer;   // arbitrate the parked entries; input is ignored
  } ctrlStrobes_t;
endpackage

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter #(
  parameter int WAYS  = 4,
  parameter int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             candValid,
  input  logic [WAYS-1:0][IDX_W-1:0]  candPort,
  input  logic                        bufBusy,
  output dispatch_pkg::ctrlStrobes_t  ctrl,
  output logic [WAYS-1:0]             winMask,
  output logic [WAYS-1:0]             keepMask
);
  // Stateless fixed priority: a lower slot always beats a higher one
  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      winMask[i] = candValid[i];
      for (int j = 0; j < i; j++) begin
        if (candValid[j] && (candPort[j] == candPort[i])) winMask[i] = 1'b0;
      end
      keepMask[i] = candValid[i] & ~winMask[i];
    end
  end

  always_comb begin
    ctrl.loadFromInput = ~bufBusy;
    ctrl.drainBuffer   = bufBusy;
  end
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [WAYS-1:0]                  inValid,
  input  logic [WAYS-1:0][TAG_W-1:0]       inTag,
  input  logic [WAYS-1:0][DATA_W-1:0]      inData,
  input  dispatch_pkg::ctrlStrobes_t       ctrl,
  input  logic [WAYS-1:0]                  winMask,
  input  logic [WAYS-1:0]                  keepMask,
  output logic [WAYS-1:0]                  candValid,
  output logic [WAYS-1:0][IDX_W-1:0]       candPort,
  output logic                             bufBusy,
  output logic [WAYS-1:0]                  outValid,
  output logic [WAYS-1:0][TAG_W-1:0]       outTag,
  output logic [WAYS-1:0][DATA_W-1:0]      outData
);
  logic [WAYS-1:0]              bufValid;
  logic [WAYS-1:0][TAG_W-1:0]   bufTag;
  logic [WAYS-1:0][DATA_W-1:0]  bufData;
  logic [WAYS-1:0][TAG_W-1:0]   candTag;
  logic [WAYS-1:0][DATA_W-1:0]  candData;

  // Holding buffer: slot 0 can never lose, so it owns no entry
  for (genvar i = 0; i < WAYS; i++) begin : g_slot
    if (i == 0) begin : g_none
      assign bufValid[i] = 1'b0;
      assign bufTag[i]   = '0;
      assign bufData[i]  = '0;
    end else begin : g_hold
      logic              holdV;
      logic [TAG_W-1:0]  holdT;
      logic [DATA_W-1:0] holdD;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          holdV <= 1'b0;
          holdT <= '0;
          holdD <= '0;
        end else begin
          holdV <= keepMask[i];
          if (ctrl.loadFromInput && keepMask[i]) begin
            holdT <= inTag[i];
            holdD <= inData[i];
          end
        end
      end
      assign bufValid[i] = holdV;
      assign bufTag[i]   = holdT;
      assign bufData[i]  = holdD;
    end

    // Candidate source: live input or parked entry
    assign candValid[i] = ctrl.drainBuffer ? bufValid[i] : inValid[i];
    assign candTag[i]   = ctrl.drainBuffer ? bufTag[i]   : inTag[i];
    assign candData[i]  = ctrl.drainBuffer ? bufData[i]  : inData[i];

    if (WAYS > 1) begin : g_idx
      assign candPort[i] = candTag[i][IDX_W-1:0];
    end else begin : g_idx1
      assign candPort[i] = '0;
    end
  end

  assign bufBusy = |bufValid;

  // Per-port routing and insert registers
  for (genvar p = 0; p < WAYS; p++) begin : g_port
    logic              selV;
    logic [TAG_W-1:0]  selT;
    logic [DATA_W-1:0] selD;
    always_comb begin
      selV = 1'b0;
      selT = '0;
      selD = '0;
      for (int i = 0; i < WAYS; i++) begin
        if (winMask[i] && (candPort[i] == IDX_W'(p))) begin
          selV = 1'b1;
          selT = selT | candTag[i];
          selD = selD | candData[i];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        outValid[p] <= 1'b0;
        outTag[p]   <= '0;
        outData[p]  <= '0;
      end else begin
        outValid[p] <= selV;
        if (selV) begin
          outTag[p]  <= selT;
          outData[p] <= selD;
        end
      end
    end
  end
endmodule

// File: rtl/sorter_dispatch.sv
module sorter_dispatch #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WAYS-1:0]              inValid,
  input  logic [WAYS-1:0][TAG_W-1:0]   inTag,
  input  logic [WAYS-1:0][DATA_W-1:0]  inData,
  output logic [WAYS-1:0]              outValid,
  output logic [WAYS-1:0][TAG_W-1:0]   outTag,
  output logic [WAYS-1:0][DATA_W-1:0]  outData,
  output logic                         stall
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  dispatch_pkg::ctrlStrobes_t    ctrl;
  logic [WAYS-1:0]               candValid;
  logic [WAYS-1:0][IDX_W-1:0]    candPort;
  logic [WAYS-1:0]               winMask;
  logic [WAYS-1:0]               keepMask;
  logic                          bufBusy;

  dispatch_arbiter #(.WAYS(WAYS), .IDX_W(IDX_W)) u_ctrl (
    .candValid(candValid), .candPort(candPort), .bufBusy(bufBusy),
    .ctrl(ctrl), .winMask(winMask), .keepMask(keepMask)
  );

  dispatch_datapath #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .inValid(inValid), .inTag(inTag), .inData(inData),
    .ctrl(ctrl), .winMask(winMask), .keepMask(keepMask),
    .candValid(candValid), .candPort(candPort), .bufBusy(bufBusy),
    .outValid(outValid), .outTag(outTag), .outData(outData)
  );

  assign stall = bufBusy;
endmodule

// File: rtl/sorter_dispatch_checker.sv
module sorter_dispatch_checker #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [WAYS-1:0]              inValid,
  input logic [WAYS-1:0][TAG_W-1:0]   inTag,
  input logic [WAYS-1:0]              outValid,
  input logic                         stall
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  logic [IDX_W-1:0] slot0Port;
  if (WAYS > 1) begin : g_p
    assign slot0Port = inTag[0][IDX_W-1:0];
  end else begin : g_p1
    assign slot0Port = '0;
  end

  // R2: slot 0 always wins its port when accepted
  assert_slot0_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && inValid[0]) |=> outValid[$past(slot0Port)]);

  // R4: a set of at most one entry cannot collide
  assert_single_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ($countones(inValid) <= 1)) |=> !stall);

  // R6: every drain cycle makes progress
  assert_drain_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (outValid != '0));

  // R6: drain never sends more than the buffer can hold
  assert_drain_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($countones(outValid) < WAYS));

  // R1: accepted set yields no more inserts than valid entries
  assert_accept_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> ($countones(outValid) <= $countones($past(inValid))));
endmodule

bind sorter_dispatch sorter_dispatch_checker #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag),
  .outValid(outValid), .stall(stall)
);

// File: tb/sorter_dispatch_tb.sv
`timescale 1ns/1ps
module sorter_dispatch_tb;
  localparam int W = 4;
  localparam int TW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]          inValid = '0;
  logic [W-1:0][TW-1:0]  inTag = '0;
  logic [W-1:0][DW-1:0]  inData = '0;
  logic [W-1:0]          outValid;
  logic [W-1:0][TW-1:0]  outTag;
  logic [W-1:0][DW-1:0]  outData;
  logic                  stall;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  sorter_dispatch #(.WAYS(W), .TAG_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag), .inData(inData),
    .outValid(outValid), .outTag(outTag), .outData(outData), .stall(stall)
  );

  function automatic logic [DW-1:0] payload(input logic [TW-1:0] t);
    return {8'hD0, t};
  endfunction

  // Called at a falling edge: present a set, move to the next falling edge
  task automatic step(input logic [W-1:0] v, input logic [W-1:0][TW-1:0] t);
    inValid = v;
    inTag = t;
    for (int i = 0; i < W; i++) inData[i] = payload(t[i]);
    @(negedge clk);
    inValid = '0;
  endtask

  task automatic idle();
    inValid = '0;
    @(negedge clk);
  endtask

  // Expected per-port strobes, tags and stall; tag fixes the payload
  task automatic expect_out(input logic [W-1:0] ev, input logic [W-1:0][TW-1:0] et,
                            input logic es, input string req);
    for (int p = 0; p < W; p++) begin
      vectors++;
      if (outValid[p] !== ev[p]) begin
        miscompares++;
        $display("FAIL %s port%0d valid actual=%b expected=%b", req, p, outValid[p], ev[p]);
      end else if (ev[p] && (outTag[p] !== et[p] || outData[p] !== payload(et[p]))) begin
        miscompares++;
        $display("FAIL %s port%0d tag/data actual=%h/%h expected=%h/%h",
                 req, p, outTag[p], outData[p], et[p], payload(et[p]));
      end
    end
    vectors++;
    if (stall !== es) begin
      miscompares++;
      $display("FAIL %s stall actual=%b expected=%b", req, stall, es);
    end
  endtask

  task automatic test_reset();  // R9
    expect_out(4'b0000, '0, 1'b0, "R9");
  endtask

  task automatic test_no_conflict();  // R7, R1
    step(4'b1111, {8'h43, 8'h32, 8'h21, 8'h10});
    expect_out(4'b1111, {8'h43, 8'h32, 8'h21, 8'h10}, 1'b0, "R7");
    idle();
    expect_out(4'b0000, '0, 1'b0, "R1");
  endtask

  task automatic test_pair_and_ignore();  // R2, R3, R4, R5
    step(4'b1111, {8'h0F, 8'h02, 8'h09, 8'h05});
    expect_out(4'b1110, {8'h0F, 8'h02, 8'h05, 8'h00}, 1'b1, "R2");
    // offered while stalled: must vanish
    step(4'b1111, {8'h70, 8'h71, 8'h72, 8'h73});
    expect_out(4'b0010, {8'h00, 8'h00, 8'h09, 8'h00}, 1'b0, "R3");
    idle();
    expect_out(4'b0000, '0, 1'b0, "R5");
    idle();
    expect_out(4'b0000, '0, 1'b0, "R5");
  endtask

  task automatic test_all_one_port();  // R6, R4
    step(4'b1111, {8'h0E, 8'h0A, 8'h06, 8'h02});
    expect_out(4'b0100, {8'h00, 8'h02, 8'h00, 8'h00}, 1'b1, "R6");
    idle();
    expect_out(4'b0100, {8'h00, 8'h06, 8'h00, 8'h00}, 1'b1, "R6");
    idle();
    expect_out(4'b0100, {8'h00, 8'h0A, 8'h00, 8'h00}, 1'b1, "R6");
    idle();
    expect_out(4'b0100, {8'h00, 8'h0E, 8'h00, 8'h00}, 1'b0, "R4");
  endtask

  task automatic test_invalid_slots();  // R8
    step(4'b0101, {8'h04, 8'h01, 8'h08, 8'h00});
    expect_out(4'b0011, {8'h00, 8'h00, 8'h01, 8'h00}, 1'b0, "R8");
  endtask

  task automatic test_two_groups();  // R6
    step(4'b1111, {8'h17, 8'h13, 8'h14, 8'h10});
    expect_out(4'b1001, {8'h13, 8'h00, 8'h00, 8'h10}, 1'b1, "R6");
    idle();
    expect_out(4'b1001, {8'h17, 8'h00, 8'h00, 8'h14}, 1'b0, "R6");
  endtask

  task automatic test_three_plus_one();  // R6, R3
    step(4'b1111, {8'h2D, 8'h20, 8'h25, 8'h21});
    expect_out(4'b0011, {8'h00, 8'h00, 8'h21, 8'h20}, 1'b1, "R6");
    idle();
    expect_out(4'b0010, {8'h00, 8'h00, 8'h25, 8'h00}, 1'b1, "R3");
    idle();
    expect_out(4'b0010, {8'h00, 8'h00, 8'h2D, 8'h00}, 1'b0, "R6");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_no_conflict();
    test_pair_and_ignore();
    test_all_one_port();
    test_invalid_slots();
    test_two_groups();
    test_three_plus_one();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule